// File: doc/BRIEF.md
# System Control Register Bank

This block is the privileged control-register file that sits beside a CPU core and answers its register-move requests. Each request names a primary register number, a secondary selector, two opcode fields, a direction, write data and whether the requester runs in user mode. The bank decides whether that combination is a legal access, stores legal writes after a fixed per-register mask, returns the stored word for legal reads and reports done or refused one clock later.

The opcode_2 field chooses between two banks. With opcode_2 zero the primary bank holds the identification word, the control register, the translation base, domain control, fault status and address, a data cache lock bit, a process identifier, four debug words picked by the secondary selector, and an access register. With opcode_2 nonzero only the cache type word and an auxiliary control register exist. Cache, TLB and lock-down operations are accepted or refused by their selector pairs but hold no state. Bit 13 of the access register is driven out so that a neighbouring bank can use it as its enable.

Top module: `sysctl_regbank`

## Requirements
- R1: A request with `req_user` high is refused and changes no stored register.
- R2: A request with a nonzero `req_op1` is refused and changes no stored register.
- R3: Every request cycle is followed, exactly one clock later, by a response with `rsp_valid` high and exactly one of `rsp_ok` or `rsp_err` high; a cycle without a request is followed by `rsp_valid` low.
- R4: After reset, reading number 0 with opcode_2 zero gives 0x69052000, number 0 with opcode_2 nonzero gives 0x0B1AA1AA, number 1 with opcode_2 zero gives 0x00000078, and every other register reads zero.
- R5: A write to the control register (number 1, opcode_2 zero) stores `(wdata & 0x00003B87) | 0x00000078`; writes to number 0 in either bank are accepted and ignored.
- R6: Numbers 0 and 1 need selector 0 with any opcode_2; with opcode_2 nonzero, number 1 is the auxiliary register and stores `wdata & 0x33`, leaving the control register untouched.
- R7: Number 7 accepts only the (opcode_2, selector) pairs (0,5) (0,6) (0,7) (1,5) (1,6) (1,10) (4,10) (5,2) (6,5); number 8 accepts opcode_2 0 with selector 5..7 and opcode_2 1 with selector 5 or 6; writes to either are discarded and reads return zero.
- R8: Numbers 4, 11 and 12 are always refused; numbers 2, 3, 5, 6 and 13 need selector 0 and opcode_2 0.
- R9: Stored masks are translation base 0xFFFFC000 (number 2), fault status 0x000006FF (number 5), process ID 0xFE000000 (number 13), data cache lock 0x1 (number 9, opcode_2 0); domain control (number 3) and fault address (number 6) keep all bits.
- R10: Number 14 needs opcode_2 0 and selector 0, 3, 4, 8 or 9; selectors 3, 4, 8, 9 are four independent full-width debug registers; a selector 0 write is accepted and not stored, and selector 0 reads zero.
- R11: Number 15 needs selector 1 and opcode_2 0 and stores `wdata & 0x00003FFF`; `ext_bank_en` equals bit 13 of that register and changes on the same clock edge that returns the write response.
- R12: Refused responses and write responses carry `rsp_rdata` of zero; a refused write changes nothing, including `ext_bank_en`.
- R13: Numbers 9 and 10 need selector 0 or 1 and opcode_2 0 or 1; writes to number 10 and to number 9 with opcode_2 1 are discarded, and those reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Requester is in user mode |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary selector |
| req_op1 | input | 3 | Opcode_1 field, must be zero |
| req_op2 | input | 3 | Opcode_2 field, picks the bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Access was done |
| rsp_err | output | 1 | Access was refused |
| rsp_rdata | output | 32 | Read data for a done read, else zero |
| ext_bank_en | output | 1 | Bit 13 of the access register |

## Verification
Every response, and any change of `ext_bank_en` caused by a write, is due on the first rising edge after the edge that captured the request, so the bench drives a request at a falling edge and compares the outputs at the next falling edge, half a period after they settle. A behavioural model in the bench predicts the legality, read data and enable for each request from its own state before applying the write, and idle cycles are checked for a dropped `rsp_valid`. The checker adds one-cycle implications on the response and the enable, so a late or early result is caught in both places.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W   = 32;
    localparam int REG_W    = 4;
    localparam int OPC_W    = 3;
    localparam int DBG_N    = 4;
    localparam int DBG_IW   = $clog2(DBG_N);
    localparam int GATE_BIT = 13;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h0000_3B87;
    localparam logic [DATA_W-1:0] CTRL_FORCE = 32'h0000_0078;
    localparam logic [DATA_W-1:0] CTRL_INIT  = 32'h0000_0078;
    localparam logic [DATA_W-1:0] AUX_KEEP   = 32'h0000_0033;
    localparam logic [DATA_W-1:0] TTB_KEEP   = 32'hFFFF_C000;
    localparam logic [DATA_W-1:0] FSR_KEEP   = 32'h0000_06FF;
    localparam logic [DATA_W-1:0] PID_KEEP   = 32'hFE00_0000;
    localparam logic [DATA_W-1:0] DCL_KEEP   = 32'h0000_0001;
    localparam logic [DATA_W-1:0] ACC_KEEP   = 32'h0000_3FFF;

    // Storage target chosen by the decoder
    typedef enum logic [3:0] {
        TGT_ZERO,
        TGT_IDENT,
        TGT_CTYPE,
        TGT_CTRL,
        TGT_AUX,
        TGT_TTB,
        TGT_DAC,
        TGT_FSR,
        TGT_FAR,
        TGT_DCL,
        TGT_PID,
        TGT_DBG,
        TGT_ACC
    } tgt_e;

    typedef struct packed {
        logic              legal;
        tgt_e              tgt;
        logic [DBG_IW-1:0] dbg_idx;
    } dec_t;

    // Debug selector values 3, 4, 8, 9 map to slots 0..3
    function automatic logic dbg_sel_hit(input logic [REG_W-1:0] sel);
        return (sel == 4'd3) || (sel == 4'd4) || (sel == 4'd8) || (sel == 4'd9);
    endfunction

    function automatic logic [DBG_IW-1:0] dbg_slot(input logic [REG_W-1:0] sel);
        return {sel[3], sel[0] ^ sel[3]};
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic             user,
    input  logic [REG_W-1:0] crn,
    input  logic [REG_W-1:0] crm,
    input  logic [OPC_W-1:0] op1,
    input  logic [OPC_W-1:0] op2,
    output dec_t             dec
);

    logic pair_ok;
    logic sel0;
    logic opz;

    assign sel0 = (crm == '0);
    assign opz  = (op2 == '0);

    // Per-number legality of the (opcode_2, selector) pair
    always_comb begin
        pair_ok = 1'b0;
        unique case (crn)
            4'd0, 4'd1:                   pair_ok = sel0;
            4'd2, 4'd3, 4'd5, 4'd6, 4'd13: pair_ok = sel0 && opz;
            4'd7: begin
                unique case (op2)
                    3'd0:    pair_ok = (crm >= 4'd5) && (crm <= 4'd7);
                    3'd1:    pair_ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd10);
                    3'd4:    pair_ok = (crm == 4'd10);
                    3'd5:    pair_ok = (crm == 4'd2);
                    3'd6:    pair_ok = (crm == 4'd5);
                    default: pair_ok = 1'b0;
                endcase
            end
            4'd8:        pair_ok = (opz && (crm >= 4'd5) && (crm <= 4'd7))
                                || ((op2 == 3'd1) && ((crm == 4'd5) || (crm == 4'd6)));
            4'd9, 4'd10: pair_ok = (crm <= 4'd1) && (op2 <= 3'd1);
            4'd14:       pair_ok = opz && (sel0 || dbg_sel_hit(crm));
            4'd15:       pair_ok = opz && (crm == 4'd1);
            default:     pair_ok = 1'b0;
        endcase
    end

    // Storage target: bank by opcode_2, then by number
    always_comb begin
        dec.legal   = pair_ok && !user && (op1 == '0);
        dec.tgt     = TGT_ZERO;
        dec.dbg_idx = dbg_slot(crm);
        if (!opz) begin
            if (crn == 4'd0)      dec.tgt = TGT_CTYPE;
            else if (crn == 4'd1) dec.tgt = TGT_AUX;
        end else begin
            unique case (crn)
                4'd0:    dec.tgt = TGT_IDENT;
                4'd1:    dec.tgt = TGT_CTRL;
                4'd2:    dec.tgt = TGT_TTB;
                4'd3:    dec.tgt = TGT_DAC;
                4'd5:    dec.tgt = TGT_FSR;
                4'd6:    dec.tgt = TGT_FAR;
                4'd9:    dec.tgt = TGT_DCL;
                4'd13:   dec.tgt = TGT_PID;
                4'd14:   dec.tgt = dbg_sel_hit(crm) ? TGT_DBG : TGT_ZERO;
                4'd15:   dec.tgt = TGT_ACC;
                default: dec.tgt = TGT_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDENT_WORD = 32'h6905_2000,
    parameter logic [DATA_W-1:0] CTYPE_WORD = 32'h0B1A_A1AA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  tgt_e              tgt,
    input  logic [DBG_IW-1:0] dbg_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              gate
);

    logic [DATA_W-1:0] ctrl_q, aux_q, ttb_q, dac_q, fsr_q, far_q, dcl_q, pid_q, acc_q;
    logic [DATA_W-1:0] dbg_q [DBG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_INIT;
            aux_q  <= '0;
            ttb_q  <= '0;
            dac_q  <= '0;
            fsr_q  <= '0;
            far_q  <= '0;
            dcl_q  <= '0;
            pid_q  <= '0;
            acc_q  <= '0;
        end else if (we) begin
            unique case (tgt)
                TGT_CTRL: ctrl_q <= (wdata & CTRL_KEEP) | CTRL_FORCE;
                TGT_AUX:  aux_q  <= wdata & AUX_KEEP;
                TGT_TTB:  ttb_q  <= wdata & TTB_KEEP;
                TGT_DAC:  dac_q  <= wdata;
                TGT_FSR:  fsr_q  <= wdata & FSR_KEEP;
                TGT_FAR:  far_q  <= wdata;
                TGT_DCL:  dcl_q  <= wdata & DCL_KEEP;
                TGT_PID:  pid_q  <= wdata & PID_KEEP;
                TGT_ACC:  acc_q  <= wdata & ACC_KEEP;
                default:  ;
            endcase
        end
    end

    for (genvar g = 0; g < DBG_N; g++) begin : g_dbg
        always_ff @(posedge clk) begin
            if (rst)
                dbg_q[g] <= '0;
            else if (we && (tgt == TGT_DBG) && (dbg_idx == DBG_IW'(g)))
                dbg_q[g] <= wdata;
        end
    end

    always_comb begin
        unique case (tgt)
            TGT_IDENT: rdata = IDENT_WORD;
            TGT_CTYPE: rdata = CTYPE_WORD;
            TGT_CTRL:  rdata = ctrl_q;
            TGT_AUX:   rdata = aux_q;
            TGT_TTB:   rdata = ttb_q;
            TGT_DAC:   rdata = dac_q;
            TGT_FSR:   rdata = fsr_q;
            TGT_FAR:   rdata = far_q;
            TGT_DCL:   rdata = dcl_q;
            TGT_PID:   rdata = pid_q;
            TGT_DBG:   rdata = dbg_q[dbg_idx];
            TGT_ACC:   rdata = acc_q;
            default:   rdata = '0;
        endcase
    end

    assign gate = acc_q[GATE_BIT];

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDENT_WORD = 32'h6905_2000,
    parameter logic [DATA_W-1:0] CTYPE_WORD = 32'h0B1A_A1AA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [REG_W-1:0]  req_crn,
    input  logic [REG_W-1:0]  req_crm,
    input  logic [OPC_W-1:0]  req_op1,
    input  logic [OPC_W-1:0]  req_op2,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ext_bank_en
);

    dec_t              dec;
    logic [DATA_W-1:0] store_rdata;
    logic              wr_fire;

    sysctl_decode u_decode (
        .user (req_user),
        .crn  (req_crn),
        .crm  (req_crm),
        .op1  (req_op1),
        .op2  (req_op2),
        .dec  (dec)
    );

    assign wr_fire = req_valid && req_write && dec.legal;

    sysctl_store #(
        .IDENT_WORD (IDENT_WORD),
        .CTYPE_WORD (CTYPE_WORD)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_fire),
        .tgt     (dec.tgt),
        .dbg_idx (dec.dbg_idx),
        .wdata   (req_wdata),
        .rdata   (store_rdata),
        .gate    (ext_bank_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= req_valid && dec.legal;
            rsp_err   <= req_valid && !dec.legal;
            rsp_rdata <= (req_valid && dec.legal && !req_write) ? store_rdata : '0;
        end
    end

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_user,
    input logic [REG_W-1:0]  req_crn,
    input logic [REG_W-1:0]  req_crm,
    input logic [OPC_W-1:0]  req_op1,
    input logic [OPC_W-1:0]  req_op2,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              ext_bank_en
);

    logic acc_write_req;
    assign acc_write_req = req_valid && req_write && (req_crn == 4'd15);

    logic ctrl_read_req;
    assign ctrl_read_req = req_valid && !req_write && !req_user && (req_crn == 4'd1)
                        && (req_crm == '0) && (req_op1 == '0) && (req_op2 == '0);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) else $error("rsp_valid missing"); // R3

    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid) else $error("spurious rsp_valid"); // R3

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_ok, rsp_err}) == 1) else $error("outcome not exclusive"); // R3

    AST_USER_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_user) |=> rsp_err) else $error("user access accepted"); // R1

    AST_OP1_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op1 != '0)) |=> rsp_err) else $error("opcode_1 access accepted"); // R2

    AST_HOLE_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ((req_crn == 4'd4) || (req_crn == 4'd11) || (req_crn == 4'd12))) |=> rsp_err)
        else $error("reserved number accepted"); // R8

    AST_CTRL_FORCED_ONES: assert property (@(posedge clk) disable iff (rst)
        ctrl_read_req |=> (rsp_rdata[6:3] == 4'hF)) else $error("control forced bits low"); // R5

    AST_REFUSED_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0)) else $error("refused data nonzero"); // R12

    AST_USER_KEEPS_GATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_user) |=> $stable(ext_bank_en)) else $error("user write moved enable"); // R12

    AST_GATE_ONLY_ON_ACC_WRITE: assert property (@(posedge clk) disable iff (rst)
        !acc_write_req |=> $stable(ext_bank_en)) else $error("enable moved without write"); // R11

endmodule

bind sysctl_regbank sysctl_regbank_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_user    (req_user),
    .req_crn     (req_crn),
    .req_crm     (req_crm),
    .req_op1     (req_op1),
    .req_op2     (req_op2),
    .rsp_valid   (rsp_valid),
    .rsp_ok      (rsp_ok),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .ext_bank_en (ext_bank_en)
);

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_user;
    logic [3:0]  req_crn, req_crm;
    logic [2:0]  req_op1, req_op2;
    logic [31:0] req_wdata;
    logic        rsp_valid, rsp_ok, rsp_err, ext_bank_en;
    logic [31:0] rsp_rdata;

    always #2 clk = ~clk;

    sysctl_regbank dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_write (req_write), .req_user (req_user),
        .req_crn (req_crn), .req_crm (req_crm), .req_op1 (req_op1), .req_op2 (req_op2),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_ok (rsp_ok), .rsp_err (rsp_err),
        .rsp_rdata (rsp_rdata), .ext_bank_en (ext_bank_en)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // ---------------- behavioural reference model ----------------
    int unsigned m_main [16];
    int unsigned m_alt  [16];
    int unsigned m_dbg  [16];

    function automatic void m_reset();
        foreach (m_main[i]) begin m_main[i] = 0; m_alt[i] = 0; m_dbg[i] = 0; end
        m_main[1] = 32'h78;
    endfunction

    function automatic bit m_legal(bit user, int crn, int crm, int op1, int op2);
        int pairs7[$] = '{16*0+5, 16*0+6, 16*0+7, 16*1+5, 16*1+6, 16*1+10, 16*4+10, 16*5+2, 16*6+5};
        int pairs8[$] = '{5, 6, 7, 16+5, 16+6};
        int key = op2 * 16 + crm;
        if (user || op1 != 0) return 0;
        if (crn == 0 || crn == 1) return crm == 0;
        if (crn inside {2, 3, 5, 6, 13}) return crm == 0 && op2 == 0;
        if (crn == 7) return (key inside {pairs7});
        if (crn == 8) return (key inside {pairs8});
        if (crn == 9 || crn == 10) return crm < 2 && op2 < 2;
        if (crn == 14) return op2 == 0 && (crm inside {0, 3, 4, 8, 9});
        if (crn == 15) return op2 == 0 && crm == 1;
        return 0;
    endfunction

    function automatic int unsigned m_read(int crn, int crm, int op2);
        if (op2 != 0) begin
            if (crn == 0) return 32'h0B1AA1AA;
            return m_alt[crn];
        end
        if (crn == 0) return 32'h69052000;
        if (crn == 14) return (crm inside {3, 4, 8, 9}) ? m_dbg[crm] : 0;
        return m_main[crn];
    endfunction

    function automatic void m_write(int crn, int crm, int op2, int unsigned d);
        if (op2 != 0) begin
            if (crn == 1) m_alt[1] = d & 32'h33;
            return;
        end
        case (crn)
            1:  m_main[1]  = (d & 32'h3B87) | 32'h78;
            2:  m_main[2]  = d & 32'hFFFFC000;
            3:  m_main[3]  = d;
            5:  m_main[5]  = d & 32'h6FF;
            6:  m_main[6]  = d;
            9:  m_main[9]  = d & 32'h1;
            13: m_main[13] = d & 32'hFE000000;
            14: if (crm inside {3, 4, 8, 9}) m_dbg[crm] = d;
            15: m_main[15] = d & 32'h3FFF;
            default: ;
        endcase
    endfunction

    // ---------------- stimulus and checking ----------------
    task automatic fail_line(string tag, string what, int unsigned act, int unsigned exp);
        n_fail++;
        $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    endtask

    // Drive one request at a falling edge; compare the response one clock later
    task automatic issue(string tag, bit wr, bit user, int crn, int crm, int op1, int op2,
                         int unsigned d);
        bit          e_ok;
        int unsigned e_data;
        bit          e_gate;
        req_valid = 1'b1; req_write = wr; req_user = user;
        req_crn = 4'(crn); req_crm = 4'(crm); req_op1 = 3'(op1); req_op2 = 3'(op2);
        req_wdata = d;
        e_ok   = m_legal(user, crn, crm, op1, op2);
        e_data = (e_ok && !wr) ? m_read(crn, crm, op2) : 0;
        if (e_ok && wr) m_write(crn, crm, op2, d);
        e_gate = m_main[15][13];
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b1 || rsp_ok !== e_ok || rsp_err !== !e_ok ||
            rsp_rdata !== e_data || ext_bank_en !== e_gate) begin
            fail_line(tag, $sformatf("crn%0d crm%0d op1 %0d op2 %0d wr%0d ok/err/en",
                      crn, crm, op1, op2, wr),
                      {rsp_valid, rsp_ok, rsp_err, ext_bank_en}, {1'b1, e_ok, !e_ok, e_gate});
            if (rsp_rdata !== e_data) fail_line(tag, "rdata", rsp_rdata, e_data);
        end
    endtask

    task automatic idle(string tag);
        req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || ext_bank_en !== m_main[15][13])
            fail_line(tag, "idle valid/enable", {rsp_valid, ext_bank_en}, {1'b0, m_main[15][13]});
    endtask

    task automatic rd(string tag, int crn, int crm, int op2);
        issue(tag, 1'b0, 1'b0, crn, crm, 0, op2, 32'h0);
    endtask

    task automatic wr(string tag, int crn, int crm, int op2, int unsigned d);
        issue(tag, 1'b1, 1'b0, crn, crm, 0, op2, d);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        req_valid = 0; req_write = 0; req_user = 0;
        req_crn = 0; req_crm = 0; req_op1 = 0; req_op2 = 0; req_wdata = 0;
        m_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4 reset state at the ports
        n_checks++;
        if (rsp_valid !== 1'b0 || ext_bank_en !== 1'b0)
            fail_line("R4", "reset valid/enable", {rsp_valid, ext_bank_en}, 0);
        rd("R4", 0, 0, 0);
        rd("R4", 0, 0, 1);
        rd("R4", 1, 0, 0);
        rd("R4", 1, 0, 2);
        foreach (m_main[i]) if (i inside {2, 3, 5, 6, 9, 13}) rd("R4", i, 0, 0);
        rd("R4", 15, 1, 0);
        rd("R4", 14, 3, 0);

        // R5 control masking and read-only identification
        wr("R5", 1, 0, 0, 32'hFFFFFFFF); rd("R5", 1, 0, 0);
        wr("R5", 1, 0, 0, 32'h0);        rd("R5", 1, 0, 0);
        wr("R5", 1, 0, 0, 32'hA5A5C003); rd("R5", 1, 0, 0);
        wr("R5", 0, 0, 0, 32'h12345678); rd("R5", 0, 0, 0);

        // R6 secondary bank
        wr("R6", 0, 0, 3, 32'hFFFFFFFF); rd("R6", 0, 0, 5);
        wr("R6", 1, 0, 2, 32'hFFFFFFFF); rd("R6", 1, 0, 1); rd("R6", 1, 0, 0);
        rd("R6", 1, 1, 1);

        // R9 masks
        wr("R9", 2, 0, 0, 32'hFFFFFFFF); rd("R9", 2, 0, 0);
        wr("R9", 3, 0, 0, 32'hDEADBEEF); rd("R9", 3, 0, 0);
        wr("R9", 5, 0, 0, 32'hFFFFFFFF); rd("R9", 5, 0, 0);
        wr("R9", 6, 0, 0, 32'hCAFEF00D); rd("R9", 6, 0, 0);
        wr("R9", 13, 0, 0, 32'hFFFFFFFF); rd("R9", 13, 0, 0);
        wr("R9", 9, 1, 0, 32'hFFFFFFFF); rd("R9", 9, 0, 0);

        // R7 full sweep of numbers 7 and 8, with writes then reads
        for (int op = 0; op < 8; op++)
            for (int s = 0; s < 16; s++) begin
                wr("R7", 7, s, op, 32'hFFFF0000 | s);
                rd("R7", 8, s, op);
            end

        // R8 refused numbers and strict selector rules
        foreach (m_main[i]) if (i inside {4, 11, 12}) begin
            wr("R8", i, 0, 0, 32'hFFFFFFFF); rd("R8", i, 0, 0);
        end
        wr("R8", 2, 1, 0, 32'h0); rd("R8", 2, 0, 0);
        wr("R8", 13, 0, 1, 32'h0); rd("R8", 13, 0, 0);
        rd("R8", 6, 2, 0);

        // R10 debug registers
        wr("R10", 14, 3, 0, 32'h11111111);
        wr("R10", 14, 4, 0, 32'h22222222);
        wr("R10", 14, 8, 0, 32'h33333333);
        wr("R10", 14, 9, 0, 32'h44444444);
        wr("R10", 14, 0, 0, 32'h55555555);
        rd("R10", 14, 3, 0); rd("R10", 14, 4, 0); rd("R10", 14, 8, 0);
        rd("R10", 14, 9, 0); rd("R10", 14, 0, 0);
        wr("R10", 14, 5, 0, 32'h0); rd("R10", 14, 3, 1);

        // R11 access register and exported enable
        wr("R11", 15, 1, 0, 32'h00002000); rd("R11", 15, 1, 0);
        wr("R11", 15, 1, 0, 32'hFFFFFFFF); rd("R11", 15, 1, 0);
        wr("R11", 15, 0, 0, 32'h0); rd("R11", 15, 2, 0);
        wr("R11", 15, 1, 1, 32'h0); idle("R11");

        // R1 user mode
        issue("R1", 1'b1, 1'b1, 15, 1, 0, 0, 32'h0);
        issue("R1", 1'b1, 1'b1, 1, 0, 0, 0, 32'h0);
        issue("R1", 1'b0, 1'b1, 0, 0, 0, 0, 32'h0);
        rd("R1", 1, 0, 0); rd("R1", 15, 1, 0);

        // R2 nonzero opcode_1
        issue("R2", 1'b1, 1'b0, 2, 0, 1, 0, 32'h0);
        issue("R2", 1'b1, 1'b0, 15, 1, 7, 0, 32'h0);
        issue("R2", 1'b0, 1'b0, 0, 0, 4, 0, 32'h0);
        rd("R2", 2, 0, 0);

        // R12 refused write keeps enable; write responses carry zero data
        wr("R12", 15, 3, 0, 32'h0); idle("R12");
        wr("R12", 3, 0, 0, 32'h0F0F0F0F);

        // R13 numbers 9 and 10
        for (int op = 0; op < 4; op++)
            for (int s = 0; s < 3; s++) begin
                wr("R13", 10, s, op, 32'hFFFFFFFF);
                rd("R13", 10, s, op);
                wr("R13", 9, s, op, 32'h0);
                rd("R13", 9, s, op);
            end

        // R3 back-to-back and gaps, then a random mix compared on every clock
        idle("R3"); rd("R3", 0, 0, 0); idle("R3"); idle("R3");
        for (int k = 0; k < 600; k++) begin
            int unsigned pick = $urandom;
            if (pick[2:0] == 3'd0) idle("R3");
            else issue("R3", pick[3], pick[7:4] == 4'd0, int'(pick[11:8]),
                       pick[12] ? int'(pick[16:13]) : int'(pick[13]),
                       pick[20:17] == 4'd0 ? int'(pick[23:21]) : 0,
                       pick[24] ? int'(pick[27:25]) : 0, $urandom);
        end
        idle("R3");
        finish_run();
    end

endmodule